// File: doc/BRIEF.md
# External and Pin-Change Interrupt Front End

This block sits between the pads of a small microcontroller and its CPU core. It watches one dedicated external interrupt pin and a group of general-purpose pins. Each pin is brought into the system clock domain through a two-flop synchronizer. The block then detects the condition that software selected for that pin and holds the pending flags. Detection uses the pad value whatever the pin direction is, so a pin that the chip drives as an output still triggers events.

The CPU sees two request lines, one for the external pin and one shared by all pin-change inputs. Each request line has its own acknowledge input, and a request reaches the CPU only when its enable bit and the global interrupt enable input are both set. When both requests are active, the external one has priority on the vector indication. Software reaches the block through a byte-wide register port with four registers: sense control, enable, flags and pin mask. A flag clears when the CPU acknowledges it, or when software writes a one to it.

Each flag is kept by a small state machine with the states FLAG_IDLE and FLAG_PEND. FLAG_IDLE goes to FLAG_PEND on a detected event. FLAG_PEND goes back to FLAG_IDLE on an acknowledge or a write-one clear, but only when no new event arrives in the same cycle. The external flag machine is also forced to FLAG_IDLE in every cycle in which low-level sensing is selected.

Top module: `irq_front`

## Requirements
- R1: After reset, all four registers read zero, and ext_req, pc_req and irq_valid are low.
- R2: Register map. Address 0 is control, with the sense select in bits 1:0. Address 1 is enable, with the external enable at bit 6 and the pin-change enable at bit 5. Address 2 is flags, with the external flag at bit 6 and the pin-change flag at bit 5. Address 3 is mask, with pin masks in bits 5:0 (bit i for pc_pins[i]). Every other bit reads zero and ignores writes.
- R3: Sense select encoding: 00 is low level, 01 is any change, 10 is falling edge, 11 is rising edge of the synchronized external pin.
- R4: If a pin level is applied before clock edge k, the resulting flag reads set after edge k+2 and still reads clear after edge k+1. A pulse held across at least one edge is detected. Events are ignored for the first three edges after reset.
- R5: In low-level mode the external flag reads zero. ext_req follows the synchronized pin: it is high while that pin is low, gated as in R8.
- R6: A flag clears on its acknowledge input or when a one is written to its bit at address 2. Writing zero bits leaves the flags unchanged.
- R7: If an event arrives in the same cycle as an acknowledge or a write-one clear, the flag stays set.
- R8: ext_req needs both the external enable and glob_ie. pc_req needs both the pin-change enable and glob_ie. Flags set whether or not the request is enabled.
- R9: A change on any unmasked pin-change input sets the one shared pin-change flag. Changes on masked inputs never set it.
- R10: irq_valid is high when either request is high. vec_pc is 0 when ext_req is high, 1 when only pc_req is high, and 0 when no request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glob_ie | input | 1 | Global interrupt enable from the CPU |
| ext_pin | input | 1 | External interrupt pad value |
| pc_pins | input | 6 | Pin-change pad values |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| ext_ack | input | 1 | CPU acknowledges the external interrupt |
| pc_ack | input | 1 | CPU acknowledges the pin-change interrupt |
| ext_req | output | 1 | External interrupt request |
| pc_req | output | 1 | Pin-change interrupt request |
| irq_valid | output | 1 | Some request is active |
| vec_pc | output | 1 | Selected vector: 0 external, 1 pin change |

## Verification
The hardest case to reach from the ports is a new event that lands on the same clock edge as a clear. Because of the synchronizer, the event reaches the flag machine two edges after the pin moves. The stimulus therefore toggles the pin, waits exactly two edges, and then places the write-one clear so that it lands on the edge where the detected change is evaluated. A behavioural model in the bench, built from delay variables rather than from the design's structure, predicts every output on every cycle. This exposes off-by-one timing in the synchronizer or in the priming logic.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_ENAB = 2'd1;
    localparam logic [1:0] REG_FLAG = 2'd2;
    localparam logic [1:0] REG_MASK = 2'd3;

    localparam int BIT_EXT = 6;
    localparam int BIT_PC  = 5;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev,
    output logic         primed
);
    localparam int PRIME = STAGES + 1;
    localparam int CW    = $clog2(PRIME + 1);

    logic [W-1:0]  stage_q [STAGES];
    logic [W-1:0]  prev_q;
    logic [CW-1:0] cnt_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            cnt_q  <= '0;
        end else begin
            prev_q <= stage_q[STAGES-1];
            if (cnt_q != CW'(PRIME)) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cur    = stage_q[STAGES-1];
    assign prev   = prev_q;
    assign primed = (cnt_q == CW'(PRIME));

endmodule

// File: rtl/ext_sense.sv
module ext_sense
    import irq_front_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  sense_e mode,
    input  logic   cur,
    input  logic   prev,
    input  logic   primed,
    input  logic   clr,
    output logic   flag,
    output logic   level_low
);
    flag_state_e st_q, st_d;
    logic        raw_ev, ev;

    always_comb begin
        unique case (mode)
            SENSE_LOW:  raw_ev = 1'b0;
            SENSE_ANY:  raw_ev = cur ^ prev;
            SENSE_FALL: raw_ev = prev & ~cur;
            SENSE_RISE: raw_ev = ~prev & cur;
            default:    raw_ev = 1'b0;
        endcase
        ev = raw_ev & primed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: if (ev)         st_d = FLAG_PEND;
            FLAG_PEND: if (!ev && clr) st_d = FLAG_IDLE;
            default:                   st_d = FLAG_IDLE;
        endcase
        if (mode == SENSE_LOW) st_d = FLAG_IDLE;
    end

    always_comb begin
        flag      = (st_q == FLAG_PEND);
        level_low = ~cur;
    end

    assert_low_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == SENSE_LOW) |=> (st_q == FLAG_IDLE));
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (st_q == FLAG_PEND));
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FLAG_PEND && clr && !ev) |=> (st_q == FLAG_IDLE));

endmodule

// File: rtl/pc_collect.sv
module pc_collect
    import irq_front_pkg::*;
#(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] mask,
    input  logic         primed,
    input  logic         clr,
    output logic         flag
);
    flag_state_e st_q, st_d;
    logic        ev;

    assign ev = primed & (|((cur ^ prev) & mask));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: if (ev)         st_d = FLAG_PEND;
            FLAG_PEND: if (!ev && clr) st_d = FLAG_IDLE;
            default:                   st_d = FLAG_IDLE;
        endcase
    end

    always_comb flag = (st_q == FLAG_PEND);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0 && st_q == FLAG_IDLE) |=> (st_q == FLAG_IDLE));
    assert_pc_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> (st_q == FLAG_PEND));

endmodule

// File: rtl/irq_front.sv
module irq_front
    import irq_front_pkg::*;
#(
    parameter int NPC    = 6,
    parameter int AW     = 2,
    parameter int DW     = 8,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          glob_ie,
    input  logic          ext_pin,
    input  logic [NPC-1:0] pc_pins,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          ext_ack,
    input  logic          pc_ack,
    output logic          ext_req,
    output logic          pc_req,
    output logic          irq_valid,
    output logic          vec_pc
);
    sense_e         mode_q;
    logic           en_ext_q, en_pc_q;
    logic [NPC-1:0] mask_q;

    logic [0:0]     ext_cur, ext_prev;
    logic           ext_primed, pc_primed;
    logic [NPC-1:0] pc_cur, pc_prev;
    logic           ext_flag, pc_flag, ext_low;
    logic           wr_ctrl, wr_enab, wr_flag, wr_mask;
    logic           clr_ext, clr_pc;

    pin_sync #(.W(1), .STAGES(STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .din(ext_pin),
        .cur(ext_cur), .prev(ext_prev), .primed(ext_primed));

    pin_sync #(.W(NPC), .STAGES(STAGES)) u_pc_sync (
        .clk(clk), .rst_n(rst_n), .din(pc_pins),
        .cur(pc_cur), .prev(pc_prev), .primed(pc_primed));

    always_comb begin
        wr_ctrl = reg_wr && (reg_addr == AW'(REG_CTRL));
        wr_enab = reg_wr && (reg_addr == AW'(REG_ENAB));
        wr_flag = reg_wr && (reg_addr == AW'(REG_FLAG));
        wr_mask = reg_wr && (reg_addr == AW'(REG_MASK));
        clr_ext = ext_ack | (wr_flag & reg_wdata[BIT_EXT]);
        clr_pc  = pc_ack  | (wr_flag & reg_wdata[BIT_PC]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= SENSE_LOW;
            en_ext_q <= 1'b0;
            en_pc_q  <= 1'b0;
            mask_q   <= '0;
        end else begin
            if (wr_ctrl) mode_q <= sense_e'(reg_wdata[1:0]);
            if (wr_enab) begin
                en_ext_q <= reg_wdata[BIT_EXT];
                en_pc_q  <= reg_wdata[BIT_PC];
            end
            if (wr_mask) mask_q <= reg_wdata[NPC-1:0];
        end
    end

    ext_sense u_ext (
        .clk(clk), .rst_n(rst_n), .mode(mode_q),
        .cur(ext_cur[0]), .prev(ext_prev[0]), .primed(ext_primed),
        .clr(clr_ext), .flag(ext_flag), .level_low(ext_low));

    pc_collect #(.W(NPC)) u_pc (
        .clk(clk), .rst_n(rst_n), .cur(pc_cur), .prev(pc_prev),
        .mask(mask_q), .primed(pc_primed), .clr(clr_pc), .flag(pc_flag));

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AW'(REG_CTRL): reg_rdata[1:0] = mode_q;
            AW'(REG_ENAB): begin
                reg_rdata[BIT_EXT] = en_ext_q;
                reg_rdata[BIT_PC]  = en_pc_q;
            end
            AW'(REG_FLAG): begin
                reg_rdata[BIT_EXT] = ext_flag;
                reg_rdata[BIT_PC]  = pc_flag;
            end
            AW'(REG_MASK): reg_rdata[NPC-1:0] = mask_q;
            default:       reg_rdata = '0;
        endcase
    end

    always_comb begin
        ext_req   = glob_ie & en_ext_q & ((mode_q == SENSE_LOW) ? ext_low : ext_flag);
        pc_req    = glob_ie & en_pc_q & pc_flag;
        irq_valid = ext_req | pc_req;
        vec_pc    = ~ext_req & pc_req;
    end

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !glob_ie |-> (!ext_req && !pc_req));
    assert_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (irq_valid && !vec_pc));
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(REG_FLAG)) |-> (reg_rdata[4:0] == 5'd0 && !reg_rdata[7]));

endmodule

// File: tb/irq_front_tb.sv
module irq_front_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glob_ie = 1'b0;
    logic       ext_pin = 1'b1;
    logic [5:0] pc_pins = 6'd0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ext_ack = 1'b0, pc_ack = 1'b0;
    logic       ext_req, pc_req, irq_valid, vec_pc;

    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    irq_front u_dut (
        .clk(clk), .rst_n(rst_n), .glob_ie(glob_ie), .ext_pin(ext_pin),
        .pc_pins(pc_pins), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_ack(ext_ack),
        .pc_ack(pc_ack), .ext_req(ext_req), .pc_req(pc_req),
        .irq_valid(irq_valid), .vec_pc(vec_pc));

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // reference model: pin delay line and register/flag state
    bit       m_x1, m_x2, m_xp;
    bit [5:0] m_c1, m_c2, m_cp, m_mask;
    int       m_age;
    bit [1:0] m_mode;
    bit       m_enx, m_enp, m_fx, m_fp;

    always @(posedge clk) begin
        bit evx, evp, ready, wf, cx, cp;
        if (!rst_n) begin
            m_x1 = 0; m_x2 = 0; m_xp = 0; m_c1 = 0; m_c2 = 0; m_cp = 0;
            m_age = 0; m_mode = 0; m_enx = 0; m_enp = 0; m_mask = 0;
            m_fx = 0; m_fp = 0;
        end else begin
            ready = (m_age >= 3);
            case (m_mode)
                2'b01:   evx = (m_x2 != m_xp);
                2'b10:   evx = m_xp && !m_x2;
                2'b11:   evx = !m_xp && m_x2;
                default: evx = 0;
            endcase
            evx = evx && ready;
            evp = ready && (((m_c2 ^ m_cp) & m_mask) != 0);
            wf  = reg_wr && reg_addr == 2'd2;
            cx  = ext_ack || (wf && reg_wdata[6]);
            cp  = pc_ack || (wf && reg_wdata[5]);
            if (m_mode == 2'b00) m_fx = 0;
            else if (evx)        m_fx = 1;
            else if (cx)         m_fx = 0;
            if (evp)     m_fp = 1;
            else if (cp) m_fp = 0;
            if (reg_wr && reg_addr == 2'd0) m_mode = reg_wdata[1:0];
            if (reg_wr && reg_addr == 2'd1) begin m_enx = reg_wdata[6]; m_enp = reg_wdata[5]; end
            if (reg_wr && reg_addr == 2'd3) m_mask = reg_wdata[5:0];
            m_xp = m_x2; m_x2 = m_x1; m_x1 = ext_pin;
            m_cp = m_c2; m_c2 = m_c1; m_c1 = pc_pins;
            if (m_age < 3) m_age++;
        end
    end

    always @(negedge clk) begin
        bit ex, ep;
        int rexp;
        #2;
        if (rst_n) begin
            ex = glob_ie && m_enx && ((m_mode == 2'b00) ? !m_x2 : m_fx);
            ep = glob_ie && m_enp && m_fp;
            case (reg_addr)
                2'd0:    rexp = m_mode;
                2'd1:    rexp = (m_enx << 6) | (m_enp << 5);
                2'd2:    rexp = (m_fx << 6) | (m_fp << 5);
                default: rexp = m_mask;
            endcase
            chk("R5/R8 ext_req model", ext_req, ex);
            chk("R8 pc_req model", pc_req, ep);
            chk("R10 irq_valid model", irq_valid, ex || ep);
            chk("R10 vec_pc model", vec_pc, !ex && ep);
            chk("R2/R6 reg_rdata model", reg_rdata, rexp);
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(5);
        // R1 reset state
        rd(2'd0, 0, "R1 ctrl"); rd(2'd1, 0, "R1 enab");
        rd(2'd2, 0, "R1 flag"); rd(2'd3, 0, "R1 mask");
        chk("R1 irq_valid", irq_valid, 0);
        // R2 reserved bits
        wr(2'd0, 8'hFC); rd(2'd0, 0, "R2 ctrl reserved");
        wr(2'd1, 8'hFF); rd(2'd1, 8'h60, "R2 enab");
        wr(2'd3, 8'hFF); rd(2'd3, 8'h3F, "R2 mask");
        wr(2'd2, 8'hFF); rd(2'd2, 0, "R2 flag w1c empty");
        wr(2'd1, 8'h00); wr(2'd3, 8'h00);
        // R3/R4 rising edge with exact timing
        wr(2'd0, 8'h03);
        ext_pin = 1'b0; step(4);
        ext_pin = 1'b1;
        step(1); step(1);
        rd(2'd2, 0, "R4 flag not yet");
        step(1);
        rd(2'd2, 8'h40, "R4 R3 rising flag");
        chk("R8 no req while disabled", ext_req, 0);
        wr(2'd1, 8'h60); glob_ie = 1'b1; step(1);
        chk("R8 ext_req enabled", ext_req, 1);
        chk("R10 vec ext", vec_pc, 0);
        // R6 ack clears
        @(negedge clk); ext_ack = 1'b1; @(negedge clk); ext_ack = 1'b0;
        rd(2'd2, 0, "R6 ack clears");
        // falling mode, write zero no change, write one clears
        wr(2'd0, 8'h02);
        ext_pin = 1'b0; step(4);
        rd(2'd2, 8'h40, "R3 falling flag");
        wr(2'd2, 8'h00); rd(2'd2, 8'h40, "R6 zero write kept");
        wr(2'd2, 8'h40); rd(2'd2, 0, "R6 w1c clears");
        ext_pin = 1'b1; step(4);
        rd(2'd2, 0, "R3 falling ignores rise");
        // any change, with R7 collision
        wr(2'd0, 8'h01);
        ext_pin = 1'b0; step(4);
        rd(2'd2, 8'h40, "R3 change flag");
        ext_pin = 1'b1;
        step(1); step(1);
        reg_addr = 2'd2; reg_wdata = 8'h40; reg_wr = 1'b1;
        step(1); reg_wr = 1'b0;
        rd(2'd2, 8'h40, "R7 event beats w1c");
        wr(2'd2, 8'h40); rd(2'd2, 0, "R7 later w1c clears");
        // R4 short pulse of two cycles, rising mode
        wr(2'd0, 8'h03);
        ext_pin = 1'b0; step(4); wr(2'd2, 8'h40);
        ext_pin = 1'b1; step(2); ext_pin = 1'b0; step(4);
        rd(2'd2, 8'h40, "R4 pulse caught");
        // R5 low-level mode
        wr(2'd0, 8'h00); step(1);
        rd(2'd2, 0, "R5 flag zero in level");
        chk("R5 req while low", ext_req, 1);
        ext_pin = 1'b1; step(1); step(1);
        chk("R5 req after rise", ext_req, 0);
        ext_pin = 1'b0; step(2);
        chk("R5 req low again", ext_req, 1);
        // R9 pin-change masking
        wr(2'd3, 8'h05);
        pc_pins = 6'b000010; step(4);
        rd(2'd2, 0, "R9 masked pin quiet");
        pc_pins = 6'b000110; step(4);
        rd(2'd2, 8'h20, "R9 unmasked pin sets");
        chk("R10 ext priority", vec_pc, 0);
        ext_pin = 1'b1; step(3);
        chk("R10 pc vector", vec_pc, 1);
        chk("R8 pc_req", pc_req, 1);
        glob_ie = 1'b0; step(1);
        chk("R8 glob gate", irq_valid, 0);
        glob_ie = 1'b1;
        @(negedge clk); pc_ack = 1'b1; @(negedge clk); pc_ack = 1'b0;
        rd(2'd2, 0, "R6 pc ack clears");
        // R7 pin change during ack
        pc_pins = 6'b000010; step(4);
        pc_pins = 6'b000011; step(2);
        pc_ack = 1'b1; step(1); pc_ack = 1'b0;
        rd(2'd2, 8'h20, "R7 pc event beats ack");
        step(3);
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        #(8 * 50000);
        nchk++; nerr++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule